// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Add-One Stage

This block is a purely combinational binary adder. It takes two operands and a carry-in, and it returns their sum with a carry-out. The word is cut into groups of unequal size, and the groups grow wider toward the most significant end. The lowest group is a plain ripple adder fed by the external carry-in. Each higher group builds only one ripple result, the one that assumes an incoming carry of 0. The result for an incoming carry of 1 comes from an increment stage. That stage finds the first 0 above the group's least significant bit and flips every bit from the bottom up to and including that 0. The carry out of the group below then picks one of the two results.

The `WIDTH` parameter picks 8, 16 or 32 bits. All three widths share the same low boundaries. For 32 bits the groups start at bits 0, 2, 4, 7, 11, 17 and 24. For 16 bits they start at 0, 2, 4, 7 and 11, and the top group ends at bit 15. For 8 bits they start at 0, 2, 4 and 7, and the top group is the single bit 7.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every input, {carryOut, sum} equals opA + opB + carryIn taken as a WIDTH+1 bit unsigned value.
- R2: A carry can enter at bit 0 and travel through every group boundary to carryOut. The case opA = all ones, opB = 0, carryIn = 1 gives sum = 0 and carryOut = 1, and 2^k - 1 + 1 gives 2^k for each group start k.
- R3: The group at bits [1:0] is a ripple adder driven directly by carryIn. A carry it produces reaches bit 2.
- R4: In every upper group, the carry-in-1 sum equals the carry-in-0 sum plus one, modulo the group size. It is formed by inverting the bits from the group's LSB up to and including the first 0.
- R5: The carry-in-1 carry of an upper group equals its carry-in-0 carry plus the overflow of that increment. No second adder is used.
- R6: An upper group outputs its carry-in-1 sum and carry when the carry from the group below is 1, and its carry-in-0 sum and carry otherwise. A group whose operand bits are all ones keeps them when no carry arrives.
- R7: With WIDTH = 16 and WIDTH = 8 the block still meets R1, using the truncated top group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| carryOut | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach from the ports is a group whose carry-in-0 sum is all ones: its increment overflows, and only that overflow, not its ripple carry, must drive the next group. The stimulus reaches it with operands of the form 2^k - 1 plus a carry-in for every group start k. It also uses pairs that fill one whole group with ones while the group below sends no carry, so that a select that picks the wrong result would show. Random vectors at all three widths cover the ordinary mixes of carries.

// File: rtl/csel_pkg.sv
package csel_pkg;

  // Number of carry-select groups for a supported word width.
  function automatic int grpCount(input int width);
    if (width <= 8) return 4;
    else if (width <= 16) return 5;
    else return 7;
  endfunction

  // Lowest bit of group idx; idx == grpCount gives the word width.
  function automatic int grpLsb(input int width, input int idx);
    int lsb;
    if (idx >= grpCount(width)) return width;
    case (idx)
      0: lsb = 0;
      1: lsb = 2;
      2: lsb = 4;
      3: lsb = 7;
      4: lsb = 11;
      5: lsb = 17;
      6: lsb = 24;
      default: lsb = width;
    endcase
    return lsb;
  endfunction

  function automatic int grpWidth(input int width, input int idx);
    return grpLsb(width, idx + 1) - grpLsb(width, idx);
  endfunction

endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W:0] chain;

  always_comb begin
    chain[0] = cin;
    for (int i = 0; i < W; i++) begin
      s[i]         = a[i] ^ b[i] ^ chain[i];
      chain[i + 1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
    end
  end

  assign cout = chain[W];
endmodule

// File: rtl/csel_add_one.sv
module csel_add_one #(
  parameter int W = 4
) (
  input  logic [W-1:0] sumZero,
  input  logic         carryZero,
  output logic [W-1:0] sumOne,
  output logic         carryOne,
  output logic         allOnes
);
  // flipCtl[k] is 1 while every lower bit of the group is 1.
  logic [W-1:0] flipCtl;

  always_comb begin
    flipCtl[0] = 1'b1;
    for (int k = 1; k < W; k++) begin
      flipCtl[k] = flipCtl[k - 1] & sumZero[k - 1];
    end
    sumOne[0] = ~sumZero[0];
    for (int k = 1; k < W; k++) begin
      sumOne[k] = flipCtl[k] ? ~sumZero[k] : sumZero[k];
    end
  end

  assign allOnes  = flipCtl[W-1] & sumZero[W-1];
  assign carryOne = carryZero | allOnes;
endmodule

// File: rtl/csel_group_select.sv
module csel_group_select #(
  parameter int W = 4
) (
  input  logic         selOne,
  input  logic [W-1:0] sumZero,
  input  logic [W-1:0] sumOne,
  input  logic         carryZero,
  input  logic         allOnes,
  output logic [W-1:0] sumOut,
  output logic         carryOut
);
  logic pickZeroN;

  assign sumOut = selOne ? sumOne : sumZero;

  // Merged carry stage: one NAND feeding one multiplexer.
  assign pickZeroN = ~(selOne & allOnes);
  assign carryOut  = pickZeroN ? carryZero : 1'b1;
endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder
  import csel_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);
  localparam int NGRP = grpCount(WIDTH);

  logic [NGRP:0]    grpCarry;
  logic [WIDTH-1:0] sum0Bus;
  logic [WIDTH-1:0] sum1Bus;
  logic [NGRP-1:0]  grpC0;
  logic [NGRP-1:0]  grpC1;

  assign grpCarry[0] = carryIn;

  for (genvar g = 0; g < NGRP; g++) begin : gGrp
    localparam int LSB = grpLsb(WIDTH, g);
    localparam int GW  = grpWidth(WIDTH, g);

    if (g == 0) begin : gBase
      logic [GW-1:0] s;
      logic          c;
      csel_ripple #(.W(GW)) u_rca (
        .a(opA[LSB +: GW]), .b(opB[LSB +: GW]), .cin(grpCarry[0]),
        .s(s), .cout(c)
      );
      assign sum[LSB +: GW]     = s;
      assign sum0Bus[LSB +: GW] = s;
      assign sum1Bus[LSB +: GW] = s;
      assign grpC0[g]           = c;
      assign grpC1[g]           = c;
      assign grpCarry[g + 1]    = c;
    end else begin : gSel
      logic [GW-1:0] s0;
      logic [GW-1:0] s1;
      logic [GW-1:0] so;
      logic          c0;
      logic          c1;
      logic          ones;
      logic          co;

      csel_ripple #(.W(GW)) u_rca (
        .a(opA[LSB +: GW]), .b(opB[LSB +: GW]), .cin(1'b0),
        .s(s0), .cout(c0)
      );
      csel_add_one #(.W(GW)) u_inc (
        .sumZero(s0), .carryZero(c0),
        .sumOne(s1), .carryOne(c1), .allOnes(ones)
      );
      csel_group_select #(.W(GW)) u_sel (
        .selOne(grpCarry[g]), .sumZero(s0), .sumOne(s1),
        .carryZero(c0), .allOnes(ones),
        .sumOut(so), .carryOut(co)
      );
      assign sum[LSB +: GW]     = so;
      assign sum0Bus[LSB +: GW] = s0;
      assign sum1Bus[LSB +: GW] = s1;
      assign grpC0[g]           = c0;
      assign grpC1[g]           = c1;
      assign grpCarry[g + 1]    = co;
    end
  end

  assign carryOut = grpCarry[NGRP];
endmodule

// File: rtl/sqrt_csel_adder_chk.sv
module sqrt_csel_adder_chk
  import csel_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0]          opA,
  input logic [WIDTH-1:0]          opB,
  input logic                      carryIn,
  input logic [WIDTH-1:0]          sum,
  input logic                      carryOut,
  input logic [WIDTH-1:0]          sum0Bus,
  input logic [WIDTH-1:0]          sum1Bus,
  input logic [grpCount(WIDTH)-1:0] grpC0,
  input logic [grpCount(WIDTH)-1:0] grpC1,
  input logic [grpCount(WIDTH):0]   grpCarry
);
  localparam int NGRP = grpCount(WIDTH);

  always_comb begin
    logic [64:0] total;
    total = 65'(opA) + 65'(opB) + 65'(carryIn);
    assert_total_R1: assert (65'({carryOut, sum}) == total);
    assert_lowgroup_R3: assert (
      3'({grpCarry[1], sum[1:0]}) == 3'(opA[1:0]) + 3'(opB[1:0]) + 3'(carryIn));
    for (int g = 1; g < NGRP; g++) begin
      logic [63:0] mask, seg0, seg1, segOut;
      int          lsb, w;
      lsb    = grpLsb(WIDTH, g);
      w      = grpWidth(WIDTH, g);
      mask   = (64'd1 << w) - 64'd1;
      seg0   = (64'(sum0Bus) >> lsb) & mask;
      seg1   = (64'(sum1Bus) >> lsb) & mask;
      segOut = (64'(sum) >> lsb) & mask;
      assert_increment_R4: assert (seg1 == ((seg0 + 64'd1) & mask));
      assert_carry_one_R5: assert (
        (64'(grpC1[g]) << w) + seg1 == (64'(grpC0[g]) << w) + seg0 + 64'd1);
      assert_select_R6: assert (grpCarry[g]
        ? (segOut == seg1 && grpCarry[g + 1] == grpC1[g])
        : (segOut == seg0 && grpCarry[g + 1] == grpC0[g]));
    end
  end
endmodule

bind sqrt_csel_adder sqrt_csel_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .opA(opA), .opB(opB), .carryIn(carryIn), .sum(sum), .carryOut(carryOut),
  .sum0Bus(sum0Bus), .sum1Bus(sum1Bus), .grpC0(grpC0), .grpC1(grpC1),
  .grpCarry(grpCarry)
);

// File: tb/sqrt_csel_adder_bench.sv
module sqrt_csel_adder_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        cin;
    logic [31:0] expSum;
    logic        expCout;
  } vec_t;

  localparam vec_t TABLE [11] = '{
    '{32'h00000000, 32'h00000000, 1'b0, 32'h00000000, 1'b0},  // R1 zero
    '{32'hFFFFFFFF, 32'h00000000, 1'b1, 32'h00000000, 1'b1},  // R2 full chain
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFFF, 1'b1},  // R1
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 32'hFFFFFFFE, 1'b1},  // R1
    '{32'h00000003, 32'h00000001, 1'b0, 32'h00000004, 1'b0},  // R3
    '{32'h00000001, 32'h00000002, 1'b1, 32'h00000004, 1'b0},  // R3
    '{32'h0000007F, 32'h00000000, 1'b1, 32'h00000080, 1'b0},  // R4
    '{32'h00FE0000, 32'h00000000, 1'b0, 32'h00FE0000, 1'b0},  // R6 no carry
    '{32'h00FF0000, 32'h00010000, 1'b0, 32'h01000000, 1'b0},  // R5
    '{32'h80000000, 32'h80000000, 1'b0, 32'h00000000, 1'b1},  // R1
    '{32'h12345678, 32'h9ABCDEF0, 1'b1, 32'hACF13569, 1'b0}   // R1
  };

  logic [31:0] a32, b32, s32;
  logic        ci32, co32;
  logic [15:0] a16, b16, s16;
  logic        ci16, co16;
  logic [7:0]  a8, b8, s8;
  logic        ci8, co8;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  sqrt_csel_adder #(.WIDTH(32)) u_sqrt_csel_adder (
    .opA(a32), .opB(b32), .carryIn(ci32), .sum(s32), .carryOut(co32));
  sqrt_csel_adder #(.WIDTH(16)) u_sqrt_csel_adder_16 (
    .opA(a16), .opB(b16), .carryIn(ci16), .sum(s16), .carryOut(co16));
  sqrt_csel_adder #(.WIDTH(8)) u_sqrt_csel_adder_8 (
    .opA(a8), .opB(b8), .carryIn(ci8), .sum(s8), .carryOut(co8));

  task automatic check32(input logic [31:0] a, input logic [31:0] b,
                         input logic cin, input logic [32:0] exp, input string req);
    @(posedge clk);
    a32 = a; b32 = b; ci32 = cin;
    @(negedge clk);
    nVec++;
    if ({co32, s32} !== exp) begin
      nBad++;
      $display("FAIL %s: a=%h b=%h cin=%0d got %h expected %h",
               req, a, b, cin, {co32, s32}, exp);
    end
  endtask

  task automatic check16(input logic [15:0] a, input logic [15:0] b, input logic cin);
    logic [16:0] exp;
    exp = 17'(a) + 17'(b) + 17'(cin);
    @(posedge clk);
    a16 = a; b16 = b; ci16 = cin;
    @(negedge clk);
    nVec++;
    if ({co16, s16} !== exp) begin
      nBad++;
      $display("FAIL R7 w16: got %h expected %h", {co16, s16}, exp);
    end
  endtask

  task automatic check8(input logic [7:0] a, input logic [7:0] b, input logic cin);
    logic [8:0] exp;
    exp = 9'(a) + 9'(b) + 9'(cin);
    @(posedge clk);
    a8 = a; b8 = b; ci8 = cin;
    @(negedge clk);
    nVec++;
    if ({co8, s8} !== exp) begin
      nBad++;
      $display("FAIL R7 w8: got %h expected %h", {co8, s8}, exp);
    end
  endtask

  initial begin
    a32 = '0; b32 = '0; ci32 = 1'b0;
    a16 = '0; b16 = '0; ci16 = 1'b0;
    a8 = '0;  b8 = '0;  ci8 = 1'b0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R1: idle state with zero operands
    @(negedge clk);
    nVec++;
    if ({co32, s32} !== 33'd0) begin
      nBad++;
      $display("FAIL R1 reset: got %h expected 0", {co32, s32});
    end

    for (int i = 0; i < 11; i++) begin
      check32(TABLE[i].a, TABLE[i].b, TABLE[i].cin,
              {TABLE[i].expCout, TABLE[i].expSum}, "R1 table");
    end

    // R2: carry crossing each group start
    foreach (csel_starts[i]) begin
      logic [32:0] ones;
      ones = (33'd1 << csel_starts[i]) - 33'd1;
      check32(ones[31:0], 32'd0, 1'b1, 33'd1 << csel_starts[i], "R2 boundary");
    end

    // R6: one group full of ones with no carry from below, via split operands
    check32(32'h00000780, 32'h00000000, 1'b0, 33'h000000780, "R6 hold");
    check32(32'h00000700, 32'h00000080, 1'b0, 33'h000000780, "R6 split");
    check32(32'h00000700, 32'h000000FF, 1'b1, 33'h000000800, "R6 carry");

    // R1: random vectors
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      logic        rc;
      ra = $urandom(); rb = $urandom(); rc = 1'($urandom());
      check32(ra, rb, rc, 33'(ra) + 33'(rb) + 33'(rc), "R1 random");
    end

    // R7: narrower widths
    check16(16'hFFFF, 16'h0000, 1'b1);
    check16(16'h07FF, 16'h0000, 1'b1);
    check8(8'hFF, 8'h00, 1'b1);
    check8(8'h7F, 8'h00, 1'b1);
    check8(8'h80, 8'h80, 1'b0);
    for (int i = 0; i < 200; i++) begin
      check16(16'($urandom()), 16'($urandom()), 1'($urandom()));
      check8(8'($urandom()), 8'($urandom()), 1'($urandom()));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  int csel_starts [7] = '{2, 4, 7, 11, 17, 24, 32};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule